// File: doc/BRIEF.md
# Sequential Stream Prefetch Buffer

This block sits next to a first-level cache and holds lines fetched ahead of demand. The lines are kept in small first-in, first-out queues, called ways, and never enter the cache. When the cache misses on a line that no way offers at its head, the least recently used way is emptied. That way then starts fetching the lines that follow the missed line, in ascending order. The cache presents each miss on the lookup port. If the head entry of some way holds that line, the block returns the data in the same cycle and drops the entry. The freed slot then queues a fetch for the next line beyond the tail of that way.

The next memory level is pipelined and accepts one request per cycle. Each request carries a tag that the memory returns with the data. Several requests can be in flight at once, and they come back in any order. Because there are several ways, several interleaved streams can be followed at the same time. Each way carries a small generation count, so data that returns for a way emptied since the request was issued is dropped. The ways are replicated through a parameter. The queue depth must be a power of two.

Top module: `stream_prefetch_buffer`

## Requirements
- R1: After reset no way holds an entry: no memory request is issued, and a lookup gives neither `lk_hit` nor `lk_stall`.
- R2: A lookup of line L that matches no way's head is a miss, with both `lk_hit` and `lk_stall` low. The victim way is emptied and refilled with lines L+1 to L+DEPTH, which are requested in ascending order.
- R3: A lookup that matches a head whose data has arrived raises `lk_hit` in the same cycle, with `lk_data` set to that line's data. The entry is removed, and the line DEPTH beyond it is queued in its place. A stream therefore hits on consecutive lines without limit.
- R4: A lookup that matches a head whose data is still outstanding raises `lk_stall` and leaves the block's state unchanged. The same lookup, held until the data arrives, then hits.
- R5: Only heads are compared. A line queued deeper in a way misses, and the way holding it keeps serving its own head.
- R6: At most one memory request is issued per cycle. The ways are served round-robin, starting after the way served last. `mem_req_tag` is {way index, slot index, generation}, with the way index in the top WAY_W bits.
- R7: Data returning for a request issued before its way was emptied is dropped. The refilled way delivers only the new stream's data.
- R8: Several ways follow interleaved streams, so alternating lookups to two running streams all hit.
- R9: The victim of a miss is the way whose last hit or refill is oldest. A stall does not count as use. After reset the order is by index, with way WAYS-1 the oldest.
- R10: Requests do not wait for returning data. After a miss with no other way wanting, the DEPTH requests go out in DEPTH consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_valid | input | 1 | Lookup present this cycle |
| lk_line | input | LINE_W | Line address looked up |
| lk_hit | output | 1 | Head hit with data present |
| lk_stall | output | 1 | Head hit with data still in flight |
| lk_data | output | DATA_W | Line data on a hit |
| mem_req_valid | output | 1 | Fetch request this cycle |
| mem_req_line | output | LINE_W | Line address to fetch |
| mem_req_tag | output | TAG_W | Tag the memory echoes back |
| mem_rsp_valid | input | 1 | Returned data present |
| mem_rsp_tag | input | TAG_W | Tag of returned data |
| mem_rsp_data | input | DATA_W | Returned line data |

## Verification
The bench probes the line right after a miss while its data is still in flight. A design that treated that case as a miss would restart a way instead of stalling. It issues five misses in a row so that a way is emptied while its first stream's fetches are outstanding, and then reads the new head. A design without generation filtering would return the stale line's data there. It looks up a line two deep in a queue, which a design comparing every entry would report as a hit. Alternating lookups over three streams, the request log, and a reference model of recency all exercise the victim choice and the round-robin order. A wrong victim choice shows up as an unexpected miss.

// File: rtl/spb_pkg.sv
package spb_pkg;
    localparam int LINE_W = 16;
    localparam int DATA_W = 32;
    localparam int GEN_W  = 2;

    typedef struct packed {
        logic              valid;
        logic              sent;
        logic              ready;
        logic [LINE_W-1:0] line;
        logic [DATA_W-1:0] data;
    } slot_t;

    function automatic logic [LINE_W-1:0] line_ahead(input logic [LINE_W-1:0] base, input int n);
        return base + LINE_W'(n);
    endfunction
endpackage

// File: rtl/spb_way.sv
module spb_way import spb_pkg::*; #(
    parameter  int DEPTH  = 4,
    localparam int SLOT_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              restart,
    input  logic [LINE_W-1:0] restart_line,
    input  logic              pop,
    input  logic [LINE_W-1:0] probe_line,
    output logic              head_match,
    output logic              head_ready,
    output logic [DATA_W-1:0] head_data,
    output logic              want,
    output logic [SLOT_W-1:0] want_slot,
    output logic [LINE_W-1:0] want_line,
    output logic [GEN_W-1:0]  gen,
    input  logic              grant,
    input  logic              fill,
    input  logic [SLOT_W-1:0] fill_slot,
    input  logic [GEN_W-1:0]  fill_gen,
    input  logic [DATA_W-1:0] fill_data
);
    slot_t             ent [DEPTH];
    logic [SLOT_W-1:0] head;
    logic [SLOT_W-1:0] idx;
    logic              fill_ok;

    assign head_match = ent[head].valid && (ent[head].line == probe_line);
    assign head_ready = ent[head].ready;
    assign head_data  = ent[head].data;
    assign want_line  = ent[want_slot].line;
    assign fill_ok    = fill && (fill_gen == gen) && ent[fill_slot].valid
                        && ent[fill_slot].sent && !ent[fill_slot].ready;

    // oldest unrequested slot, counted from the head
    always_comb begin
        want      = 1'b0;
        want_slot = '0;
        idx       = '0;
        for (int k = DEPTH - 1; k >= 0; k--) begin
            idx = head + SLOT_W'(k);
            if (ent[idx].valid && !ent[idx].sent) begin
                want      = 1'b1;
                want_slot = idx;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) ent[i] <= '0;
            head <= '0;
            gen  <= '0;
        end else if (restart) begin
            gen  <= gen + GEN_W'(1);
            head <= '0;
            for (int i = 0; i < DEPTH; i++) begin
                ent[i].valid <= 1'b1;
                ent[i].sent  <= 1'b0;
                ent[i].ready <= 1'b0;
                ent[i].line  <= line_ahead(restart_line, i);
                ent[i].data  <= '0;
            end
        end else begin
            if (grant) ent[want_slot].sent <= 1'b1;
            if (fill_ok) begin
                ent[fill_slot].ready <= 1'b1;
                ent[fill_slot].data  <= fill_data;
            end
            if (pop) begin
                ent[head].sent  <= 1'b0;
                ent[head].ready <= 1'b0;
                ent[head].line  <= line_ahead(ent[head].line, DEPTH);
                head            <= head + SLOT_W'(1);
            end
        end
    end

    assert_pop_requeues_R3: assert property (@(posedge clk) disable iff (rst)
        (pop && !restart) |=> (ent[$past(head)].valid && !ent[$past(head)].sent));
endmodule

// File: rtl/spb_rr_arb.sv
module spb_rr_arb #(
    parameter  int N     = 4,
    localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [N-1:0]     req,
    output logic [N-1:0]     grant,
    output logic [IDX_W-1:0] gidx,
    output logic             gvalid
);
    logic [IDX_W-1:0] last;

    always_comb begin
        grant  = '0;
        gidx   = '0;
        gvalid = 1'b0;
        for (int k = 1; k <= N; k++) begin
            int c;
            c = (int'(last) + k) % N;
            if (!gvalid && req[c]) begin
                gvalid   = 1'b1;
                grant[c] = 1'b1;
                gidx     = IDX_W'(c);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst)         last <= IDX_W'(N - 1);
        else if (gvalid) last <= gidx;
    end

    assert_single_grant_R6: assert property (@(posedge clk) disable iff (rst)
        $onehot0(grant) && ((grant & ~req) == '0));
    assert_rr_no_repeat_R6: assert property (@(posedge clk) disable iff (rst)
        (gvalid && $past(gvalid) && gidx == $past(gidx)) |-> ($countones(req) == 1));
endmodule

// File: rtl/spb_lru.sv
module spb_lru #(
    parameter  int N     = 4,
    localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             touch,
    input  logic [IDX_W-1:0] touch_idx,
    output logic [IDX_W-1:0] victim
);
    logic [IDX_W-1:0] rank [N];

    always_comb begin
        victim = '0;
        for (int w = 0; w < N; w++)
            if (rank[w] == IDX_W'(N - 1)) victim = IDX_W'(w);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int w = 0; w < N; w++) rank[w] <= IDX_W'(w);
        end else if (touch) begin
            for (int w = 0; w < N; w++) begin
                if (IDX_W'(w) == touch_idx)       rank[w] <= '0;
                else if (rank[w] < rank[touch_idx]) rank[w] <= rank[w] + IDX_W'(1);
            end
        end
    end

    generate if (N > 1) begin : g_chk
        assert_touched_not_victim_R9: assert property (@(posedge clk) disable iff (rst)
            touch |=> (victim != $past(touch_idx)));
    end endgenerate
endmodule

// File: rtl/stream_prefetch_buffer.sv
module stream_prefetch_buffer import spb_pkg::*; #(
    parameter  int DEPTH  = 4,
    parameter  int WAYS   = 4,
    localparam int SLOT_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int WAY_W  = (WAYS > 1) ? $clog2(WAYS) : 1,
    localparam int TAG_W  = WAY_W + SLOT_W + GEN_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              lk_valid,
    input  logic [LINE_W-1:0] lk_line,
    output logic              lk_hit,
    output logic              lk_stall,
    output logic [DATA_W-1:0] lk_data,
    output logic              mem_req_valid,
    output logic [LINE_W-1:0] mem_req_line,
    output logic [TAG_W-1:0]  mem_req_tag,
    input  logic              mem_rsp_valid,
    input  logic [TAG_W-1:0]  mem_rsp_tag,
    input  logic [DATA_W-1:0] mem_rsp_data
);
    logic [WAYS-1:0]   match_v, ready_v, want_v, gnt_v, restart_v, pop_v;
    logic [DATA_W-1:0] hdata  [WAYS];
    logic [SLOT_W-1:0] wslot  [WAYS];
    logic [LINE_W-1:0] wline  [WAYS];
    logic [GEN_W-1:0]  wgen   [WAYS];
    logic [WAY_W-1:0]  sel, victim, gidx, touch_idx, rsp_way;
    logic              found, miss, gvalid, touch;

    assign rsp_way = mem_rsp_tag[TAG_W-1 -: WAY_W];

    generate for (genvar w = 0; w < WAYS; w++) begin : g_way
        spb_way #(.DEPTH(DEPTH)) u_way (
            .clk(clk), .rst(rst),
            .restart(restart_v[w]), .restart_line(line_ahead(lk_line, 1)),
            .pop(pop_v[w]), .probe_line(lk_line),
            .head_match(match_v[w]), .head_ready(ready_v[w]), .head_data(hdata[w]),
            .want(want_v[w]), .want_slot(wslot[w]), .want_line(wline[w]), .gen(wgen[w]),
            .grant(gnt_v[w]),
            .fill(mem_rsp_valid && rsp_way == WAY_W'(w)),
            .fill_slot(mem_rsp_tag[GEN_W +: SLOT_W]),
            .fill_gen(mem_rsp_tag[GEN_W-1:0]),
            .fill_data(mem_rsp_data)
        );
    end endgenerate

    // lowest-index way whose head matches wins
    always_comb begin
        found = 1'b0;
        sel   = '0;
        for (int w = 0; w < WAYS; w++)
            if (!found && match_v[w]) begin
                found = 1'b1;
                sel   = WAY_W'(w);
            end
    end

    assign lk_hit    = lk_valid && found && ready_v[sel];
    assign lk_stall  = lk_valid && found && !ready_v[sel];
    assign lk_data   = hdata[sel];
    assign miss      = lk_valid && !found;
    assign touch     = lk_hit || miss;
    assign touch_idx = lk_hit ? sel : victim;

    always_comb begin
        pop_v     = '0;
        restart_v = '0;
        if (lk_hit) pop_v[sel]        = 1'b1;
        if (miss)   restart_v[victim] = 1'b1;
    end

    spb_lru #(.N(WAYS)) u_lru (
        .clk(clk), .rst(rst), .touch(touch), .touch_idx(touch_idx), .victim(victim)
    );

    spb_rr_arb #(.N(WAYS)) u_arb (
        .clk(clk), .rst(rst), .req(want_v), .grant(gnt_v), .gidx(gidx), .gvalid(gvalid)
    );

    assign mem_req_valid = gvalid;
    assign mem_req_line  = wline[gidx];
    assign mem_req_tag   = {gidx, wslot[gidx], wgen[gidx]};

    assert_miss_refills_R2: assert property (@(posedge clk) disable iff (rst)
        miss |=> (|want_v));
    assert_stall_no_pop_R4: assert property (@(posedge clk) disable iff (rst)
        lk_stall |-> (pop_v == '0 && restart_v == '0));
    assert_rst_empty_R1: assert property (@(posedge clk)
        $past(rst) |-> !mem_req_valid);
endmodule

// File: tb/stream_prefetch_buffer_bench.sv
module stream_prefetch_buffer_bench;
    import spb_pkg::*;
    localparam int WAYS = 4, DEPTH = 4, TAG_W = 6, LAT = 12;

    logic clk = 0, rst = 1;
    logic lk_valid = 0, lk_hit, lk_stall, mem_req_valid, mem_rsp_valid = 0;
    logic [LINE_W-1:0] lk_line = '0, mem_req_line;
    logic [DATA_W-1:0] lk_data, mem_rsp_data = '0;
    logic [TAG_W-1:0]  mem_req_tag, mem_rsp_tag = '0;

    always #5 clk = ~clk;

    stream_prefetch_buffer #(.DEPTH(DEPTH), .WAYS(WAYS)) u_stream_prefetch_buffer (
        .clk(clk), .rst(rst), .lk_valid(lk_valid), .lk_line(lk_line),
        .lk_hit(lk_hit), .lk_stall(lk_stall), .lk_data(lk_data),
        .mem_req_valid(mem_req_valid), .mem_req_line(mem_req_line), .mem_req_tag(mem_req_tag),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_tag(mem_rsp_tag), .mem_rsp_data(mem_rsp_data));

    int checks = 0, errors = 0, cyc = 0;

    function automatic logic [DATA_W-1:0] fdat(input logic [LINE_W-1:0] l);
        return {~l, l};
    endfunction

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // pipelined memory model, fixed latency, one request per cycle
    logic              pv [LAT];
    logic [TAG_W-1:0]  pt [LAT];
    logic [LINE_W-1:0] pl [LAT];
    logic [LINE_W-1:0] rl [$];
    int                rw [$];
    int                rc [$];

    always @(posedge clk) cyc <= cyc + 1;

    always @(negedge clk) begin
        if (rst) begin
            for (int i = 0; i < LAT; i++) pv[i] = 0;
            mem_rsp_valid = 0;
        end else begin
            mem_rsp_valid = pv[LAT-1];
            mem_rsp_tag   = pt[LAT-1];
            mem_rsp_data  = fdat(pl[LAT-1]);
            for (int i = LAT - 1; i > 0; i--) begin
                pv[i] = pv[i-1]; pt[i] = pt[i-1]; pl[i] = pl[i-1];
            end
            pv[0] = mem_req_valid; pt[0] = mem_req_tag; pl[0] = mem_req_line;
            if (mem_req_valid) begin
                rl.push_back(mem_req_line);
                rw.push_back(int'(mem_req_tag[TAG_W-1 -: 2]));
                rc.push_back(cyc);
            end
        end
    end

    // scoreboard
    typedef struct {bit hit; logic [DATA_W-1:0] data; logic [LINE_W-1:0] line; string req;} exp_t;
    exp_t q [$];

    always @(negedge clk) begin
        if (!rst && lk_valid && !lk_stall && q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            chk(lk_hit == e.hit, e.req, {63'd0, lk_hit}, {63'd0, e.hit});
            if (e.hit) chk(lk_data == e.data, e.req, {32'd0, lk_data}, {32'd0, e.data});
        end
    end

    // requirement-level model of stream heads and recency
    logic [LINE_W-1:0] m_head [WAYS];
    bit                m_val  [WAYS];
    int                m_rank [WAYS];

    task automatic m_touch(input int w);
        for (int v = 0; v < WAYS; v++) if (m_rank[v] < m_rank[w]) m_rank[v]++;
        m_rank[w] = 0;
    endtask

    // called at posedge+1; returns at posedge+1 after the lookup commits
    task automatic lookup(input logic [LINE_W-1:0] ln, input string req, output bit stalled);
        exp_t e;
        int   ws;
        bit   f;
        f = 0; ws = 0;
        for (int w = 0; w < WAYS; w++)
            if (!f && m_val[w] && m_head[w] == ln) begin f = 1; ws = w; end
        if (!f) for (int w = 0; w < WAYS; w++) if (m_rank[w] == WAYS - 1) ws = w;
        m_val[ws] = 1; m_head[ws] = ln + 1'b1; m_touch(ws);
        e.hit = f; e.data = fdat(ln); e.line = ln; e.req = req;
        q.push_back(e);
        lk_valid = 1; lk_line = ln;
        @(negedge clk);
        stalled = lk_stall;
        while (lk_stall) @(negedge clk);
        @(posedge clk); #1;
        lk_valid = 0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog expired actual=%0d expected=0", cyc);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        bit sf;
        bit seen [WAYS];
        for (int w = 0; w < WAYS; w++) begin m_val[w] = 0; m_rank[w] = w; end
        repeat (3) @(posedge clk);
        #1 rst = 0;
        lk_valid = 1; lk_line = 16'h0100;
        @(negedge clk);
        chk(!mem_req_valid, "R1", {63'd0, mem_req_valid}, 0);
        chk(!lk_hit && !lk_stall, "R1", {62'd0, lk_hit, lk_stall}, 0);
        lk_valid = 0;
        @(posedge clk); #1;
        rl.delete(); rw.delete(); rc.delete();

        lookup(16'h0100, "R2", sf);            // first miss, way 3 is oldest
        lookup(16'h0101, "R4", sf);            // data still in flight
        chk(sf == 1, "R4", {63'd0, sf}, 1);
        chk(rl.size() >= DEPTH, "R10", rl.size(), DEPTH);
        for (int k = 0; k < DEPTH && k < rl.size(); k++) begin
            chk(rl[k] == 16'h0101 + k, "R2", rl[k], 16'h0101 + k);
            chk(rw[k] == WAYS - 1, "R9", rw[k], WAYS - 1);
            chk(rc[k] == rc[0] + k, "R10", rc[k], rc[0] + k);
        end

        for (int i = 2; i <= 10; i++) lookup(16'h0100 + i, "R3", sf);

        lookup(16'h010D, "R5", sf);            // two deep in the queue: miss
        lookup(16'h010B, "R5", sf);            // original head still serves

        lookup(16'h0200, "R8", sf);
        for (int i = 0; i < 6; i++) begin
            lookup(16'h010C + i, "R8", sf);
            lookup(16'h0201 + i, "R8", sf);
            lookup(16'h010E + i, "R8", sf);
        end

        rl.delete(); rw.delete(); rc.delete();
        lookup(16'h0300, "R9", sf);
        lookup(16'h0400, "R9", sf);
        lookup(16'h0500, "R9", sf);
        lookup(16'h0600, "R9", sf);
        lookup(16'h0700, "R9", sf);            // empties the way with pending 0x03xx fetches
        for (int i = 1; i <= 6; i++) lookup(16'h0700 + i, "R7", sf);
        lookup(16'h0301, "R9", sf);
        lookup(16'h0601, "R9", sf);

        for (int w = 0; w < WAYS; w++) seen[w] = 0;
        for (int k = 0; k < 10 && k < rw.size(); k++) seen[rw[k]] = 1;
        for (int w = 0; w < WAYS; w++) chk(seen[w], "R6", {63'd0, seen[w]}, 1);

        repeat (LAT + 4) @(posedge clk);
        #1;
        chk(q.size() == 0, "R3", q.size(), 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule